// File: doc/BRIEF.md
# Graphics Masked Write Datapath

This block forms the write half of the data path in a two-bank graphics memory model. It keeps a 32-bit fill colour and a 32-bit per-bit write mask. It remembers for each bank whether per-bit masking was switched on when that bank was opened. Each cycle it turns the decoded command, bank, column, input data and byte masks into a group of eight column lanes. Each lane gets a write strobe and a merged word, built from the new data and the stored word that the array presents on `old_i`.

The eight-lane group always begins at the column address with its low three bits cleared. A plain write touches one lane. A block write can touch all eight lanes: it spreads the colour register over them, and the data pins carry per-column, per-byte enables instead of data. After a register-load command, the block shuts out every command except NOP for two clocks. A load that selects both registers at once is reported as an error.

Top module: `gfx_wr_path`

## Requirements
- R1: A register load (cmd_i=5) sets the colour register from data_i when col_i[6] is 1, and sets the mask register from data_i when col_i[5] is 1.
- R2: A register load with col_i[6] and col_i[5] both 1 drives srs_err_o high in that cycle and leaves both registers unchanged.
- R3: In the two clocks after an accepted register load, any cmd_i other than NOP (0) raises cmd_reject_o and has no effect: no strobe, no auto-precharge, no register or flag update.
- R4: Activate-with-mask (cmd_i=2) turns on per-bit masking for bank_i. Plain activate (cmd_i=1) turns it off. The other bank's flag is not changed.
- R5: When a write or block write goes to a bank with masking on, each bit whose mask register bit is 0 keeps its old_i value.
- R6: On a write (cmd_i=3), byte_mask_i[b] high keeps bits 8b+7:8b of the target lane at their old value in the same cycle.
- R7: A write strobes only lane col_i[2:0]. wr_col_base_o is always col_i with bits 2:0 cleared. Lane c of wr_data_o/old_i sits at bits 32c+31:32c.
- R8: A block write (cmd_i=4) writes the colour into lane c, byte b, when data_i[8b+c] is 1. It strobes lane c when any of that lane's four enable bits is 1.
- R9: auto_pre_o equals ap_i on an accepted write or block write, and is 0 for every other command.
- R10: After reset the colour register is 0, the mask register is all ones, masking is off for both banks and there is no lockout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_i | input | 3 | Decoded command: 0 NOP, 1 activate, 2 activate-with-mask, 3 write, 4 block write, 5 register load, 6/7 other |
| bank_i | input | 1 | Target bank |
| col_i | input | 8 | Column address; bits 6 and 5 select registers on a load |
| ap_i | input | 1 | Auto-precharge request |
| data_i | input | 32 | Write data, register load value, or block-write enables |
| byte_mask_i | input | 4 | Per-byte write mask, 1 = keep |
| old_i | input | 256 | Stored words of the eight lanes of the group |
| wr_stb_o | output | 8 | Per-lane write strobe |
| wr_col_base_o | output | 8 | First column of the lane group |
| wr_bank_o | output | 1 | Bank of the write |
| wr_data_o | output | 256 | Merged word per lane |
| auto_pre_o | output | 1 | Auto-precharge after this write |
| srs_err_o | output | 1 | Both registers selected in one load |
| cmd_reject_o | output | 1 | Command refused during lockout |

## Verification
The bench uses a different stored word in each lane. A design that strobed or merged the wrong lane, or ignored the byte masks, would therefore show up as a wrong word. It sends a register load as the first locked-out command, and a write with ap_i set as the second. This catches a lockout that still lets registers load or raises auto-precharge. It opens masking on one bank and writes to both, so a flag shared between banks would mask the wrong write. It also checks that a dual-select load leaves both the colour and the mask as they were.

// File: rtl/gfx_wr_pkg.sv
package gfx_wr_pkg;
  localparam int GFX_DW    = 32;
  localparam int GFX_BYTES = GFX_DW / 8;
  localparam int GFX_LANES = 8;
  localparam int GFX_LANEW = $clog2(GFX_LANES);
  localparam int GFX_COLW  = 8;
  localparam int GFX_BANKS = 2;

  localparam logic [2:0] CMD_NOP     = 3'd0;
  localparam logic [2:0] CMD_ACT     = 3'd1;
  localparam logic [2:0] CMD_ACT_WPB = 3'd2;
  localparam logic [2:0] CMD_WRITE   = 3'd3;
  localparam logic [2:0] CMD_BLOCK   = 3'd4;
  localparam logic [2:0] CMD_SRS     = 3'd5;

  // spread one enable per byte over its eight bits
  function automatic logic [GFX_DW-1:0] byte_to_bit(input logic [GFX_BYTES-1:0] be);
    logic [GFX_DW-1:0] r;
    for (int b = 0; b < GFX_BYTES; b++) r[b*8 +: 8] = {8{be[b]}};
    return r;
  endfunction

  // bitwise select between new and stored word
  function automatic logic [GFX_DW-1:0] merge_word(input logic [GFX_DW-1:0] nw,
                                                   input logic [GFX_DW-1:0] od,
                                                   input logic [GFX_DW-1:0] en);
    return (nw & en) | (od & ~en);
  endfunction

  // block-write byte enables of one lane: bit 8*b+lane enables byte b
  function automatic logic [GFX_BYTES-1:0] lane_byte_en(input logic [GFX_DW-1:0] d,
                                                        input int lane);
    logic [GFX_BYTES-1:0] r;
    for (int b = 0; b < GFX_BYTES; b++) r[b] = d[b*GFX_LANES + lane];
    return r;
  endfunction
endpackage

// File: rtl/gfx_cmd_gate.sv
module gfx_cmd_gate
  import gfx_wr_pkg::*;
#(
  parameter int LOCK_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cmd_i,
  output logic       acc_act_o,
  output logic       acc_actm_o,
  output logic       acc_wr_o,
  output logic       acc_bw_o,
  output logic       acc_srs_o,
  output logic       reject_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] lock_q;
  logic          locked;

  assign locked     = (lock_q != '0);
  assign reject_o   = locked && (cmd_i != CMD_NOP);
  assign acc_act_o  = !locked && (cmd_i == CMD_ACT);
  assign acc_actm_o = !locked && (cmd_i == CMD_ACT_WPB);
  assign acc_wr_o   = !locked && (cmd_i == CMD_WRITE);
  assign acc_bw_o   = !locked && (cmd_i == CMD_BLOCK);
  assign acc_srs_o  = !locked && (cmd_i == CMD_SRS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lock_q <= '0;
    else if (acc_srs_o) lock_q <= LW'(LOCK_CYC);
    else if (locked)    lock_q <= lock_q - 1'b1;
  end

  // R3: the command after an accepted load is refused unless it is a NOP
  p_lock_after_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_srs_o |=> (cmd_i == CMD_NOP) || reject_o);
endmodule

// File: rtl/gfx_special_regs.sv
module gfx_special_regs
  import gfx_wr_pkg::*;
#(
  parameter int DW = GFX_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          sel_color_i,
  input  logic          sel_mask_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] color_o,
  output logic [DW-1:0] mask_o,
  output logic          err_o
);
  logic [DW-1:0] color_q, mask_q;
  logic          ld_color, ld_mask;

  assign err_o    = load_i && sel_color_i && sel_mask_i;
  assign ld_color = load_i && sel_color_i && !sel_mask_i;
  assign ld_mask  = load_i && sel_mask_i && !sel_color_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      color_q <= '0;
      mask_q  <= '1;
    end else begin
      if (ld_color) color_q <= din_i;
      if (ld_mask)  mask_q  <= din_i;
    end
  end

  assign color_o = color_q;
  assign mask_o  = mask_q;

  // R2: a dual-select load leaves both registers as they were
  p_dual_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> $stable(color_q) && $stable(mask_q));
  // R1: registers only move on a load
  p_no_load_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(color_q) && $stable(mask_q));
endmodule

// File: rtl/gfx_wpb_flags.sv
module gfx_wpb_flags
  import gfx_wr_pkg::*;
#(
  parameter int NB = GFX_BANKS,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          actm_i,
  input  logic [BW-1:0] bank_i,
  output logic [NB-1:0] wpb_o
);
  logic [NB-1:0] wpb_q;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wpb_q[g] <= 1'b0;
      else if ((act_i || actm_i) && (bank_i == BW'(g))) wpb_q[g] <= actm_i;
    end
  end

  assign wpb_o = wpb_q;

  // R4: flags only change on an activate
  p_flags_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_i || actm_i) |=> $stable(wpb_q));
  // R4: an activate changes at most the addressed bank
  p_one_bank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i || actm_i) |=> $countones(wpb_q ^ $past(wpb_q)) <= 1);
endmodule

// File: rtl/gfx_lane_merge.sv
module gfx_lane_merge
  import gfx_wr_pkg::*;
#(
  parameter int LANE = 0,
  parameter int DW   = GFX_DW,
  localparam int NBY = DW / 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 is_wr_i,
  input  logic                 is_bw_i,
  input  logic [GFX_LANEW-1:0] lane_sel_i,
  input  logic [DW-1:0]        data_i,
  input  logic [NBY-1:0]       byte_mask_i,
  input  logic [DW-1:0]        color_i,
  input  logic [DW-1:0]        mask_i,
  input  logic                 wpb_on_i,
  input  logic [DW-1:0]        old_i,
  output logic                 stb_o,
  output logic [DW-1:0]        dout_o
);
  logic           hit;
  logic [NBY-1:0] be;
  logic [DW-1:0]  src, en;

  assign hit = is_wr_i && (lane_sel_i == GFX_LANEW'(LANE));

  always_comb begin
    if (is_bw_i)  be = lane_byte_en(data_i, LANE);
    else if (hit) be = ~byte_mask_i;
    else          be = '0;
  end

  assign src    = is_bw_i ? color_i : data_i;
  assign en     = byte_to_bit(be) & (wpb_on_i ? mask_i : '1);
  assign dout_o = merge_word(src, old_i, en);
  assign stb_o  = is_bw_i ? (|be) : hit;

  // R5: bits cleared in the mask register keep the stored value
  p_keep_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && wpb_on_i) |-> ((dout_o ^ old_i) & ~mask_i) == '0);
  // R6: masked bytes of a plain write keep the stored value
  p_byte_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr_i && stb_o) |-> ((dout_o ^ old_i) & byte_to_bit(byte_mask_i)) == '0);
  // R7: an unstrobed lane passes its stored word through
  p_idle_lane_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_o |-> dout_o == old_i);
endmodule

// File: rtl/gfx_wr_path.sv
module gfx_wr_path
  import gfx_wr_pkg::*;
#(
  parameter int DW    = GFX_DW,
  parameter int LANES = GFX_LANES,
  parameter int COLW  = GFX_COLW,
  localparam int NBY  = DW / 8,
  localparam int LW   = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          cmd_i,
  input  logic                bank_i,
  input  logic [COLW-1:0]     col_i,
  input  logic                ap_i,
  input  logic [DW-1:0]       data_i,
  input  logic [NBY-1:0]      byte_mask_i,
  input  logic [LANES*DW-1:0] old_i,
  output logic [LANES-1:0]    wr_stb_o,
  output logic [COLW-1:0]     wr_col_base_o,
  output logic                wr_bank_o,
  output logic [LANES*DW-1:0] wr_data_o,
  output logic                auto_pre_o,
  output logic                srs_err_o,
  output logic                cmd_reject_o
);
  logic          acc_act, acc_actm, acc_wr, acc_bw, acc_srs;
  logic [DW-1:0] color, mask;
  logic [1:0]    wpb;
  logic          wpb_on;

  gfx_cmd_gate #(.LOCK_CYC(2)) u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i),
    .acc_act_o(acc_act), .acc_actm_o(acc_actm), .acc_wr_o(acc_wr),
    .acc_bw_o(acc_bw), .acc_srs_o(acc_srs), .reject_o(cmd_reject_o)
  );

  gfx_special_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_i(acc_srs),
    .sel_color_i(col_i[6]), .sel_mask_i(col_i[5]), .din_i(data_i),
    .color_o(color), .mask_o(mask), .err_o(srs_err_o)
  );

  gfx_wpb_flags #(.NB(2)) u_wpb (
    .clk(clk), .rst_n(rst_n), .act_i(acc_act), .actm_i(acc_actm),
    .bank_i(bank_i), .wpb_o(wpb)
  );

  assign wpb_on = wpb[bank_i];

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    gfx_lane_merge #(.LANE(c), .DW(DW)) u_lane (
      .clk(clk), .rst_n(rst_n), .is_wr_i(acc_wr), .is_bw_i(acc_bw),
      .lane_sel_i(col_i[LW-1:0]), .data_i(data_i), .byte_mask_i(byte_mask_i),
      .color_i(color), .mask_i(mask), .wpb_on_i(wpb_on),
      .old_i(old_i[c*DW +: DW]), .stb_o(wr_stb_o[c]), .dout_o(wr_data_o[c*DW +: DW])
    );
  end

  assign wr_col_base_o = {col_i[COLW-1:LW], {LW{1'b0}}};
  assign wr_bank_o     = bank_i;
  assign auto_pre_o    = (acc_wr || acc_bw) && ap_i;

  // R3: a refused command produces no write
  p_reject_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject_o |-> (wr_stb_o == '0) && !auto_pre_o);
  // R7: a plain write strobes exactly one lane
  p_write_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == CMD_WRITE && !cmd_reject_o) |-> $countones(wr_stb_o) == 1);
  // R9: auto-precharge only comes with a write command
  p_ap_write_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    auto_pre_o |-> (cmd_i == CMD_WRITE || cmd_i == CMD_BLOCK));
endmodule

// File: tb/gfx_wr_path_tb.sv
module gfx_wr_path_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   cmd = 3'd0;
  logic         bank = 1'b0;
  logic [7:0]   col = 8'd0;
  logic         ap = 1'b0;
  logic [31:0]  data = 32'd0;
  logic [3:0]   bmask = 4'd0;
  logic [255:0] old;
  logic [7:0]   stb;
  logic [7:0]   base;
  logic         wbank, apo, err, rej;
  logic [255:0] wdata;

  int checks = 0;
  int errors = 0;

  logic [31:0] color_m = 32'd0;
  logic [31:0] mask_m  = 32'hFFFF_FFFF;
  logic [1:0]  wpb_m   = 2'b00;

  always #2 clk = ~clk;

  gfx_wr_path u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .bank_i(bank), .col_i(col), .ap_i(ap),
    .data_i(data), .byte_mask_i(bmask), .old_i(old), .wr_stb_o(stb),
    .wr_col_base_o(base), .wr_bank_o(wbank), .wr_data_o(wdata),
    .auto_pre_o(apo), .srs_err_o(err), .cmd_reject_o(rej)
  );

  initial begin
    for (int c = 0; c < 8; c++) old[c*32 +: 32] = 32'h3C96_A50F ^ (32'h1111_1111 * c);
  end

  // per entry: byte_mask(4) col(8) ap(1) data(32) expected strobe(8)
  localparam logic [52:0] VEC [6] = '{
    {4'b0000, 8'h00, 1'b0, 32'hDEAD_BEEF, 8'b0000_0001},
    {4'b0001, 8'h07, 1'b1, 32'h1234_5678, 8'b1000_0000},
    {4'b1010, 8'h5B, 1'b0, 32'hCAFE_F00D, 8'b0000_1000},
    {4'b1111, 8'hF2, 1'b1, 32'h0BAD_C0DE, 8'b0000_0100},
    {4'b0110, 8'h8D, 1'b0, 32'hFFFF_0000, 8'b0010_0000},
    {4'b1001, 8'h31, 1'b1, 32'h5A5A_A5A5, 8'b0000_0010}
  };

  function automatic logic [255:0] model_data(input logic is_bw, input logic is_wr,
      input logic [7:0] c_a, input logic [31:0] d, input logic [3:0] bm,
      input logic wpb_on);
    logic [255:0] r;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 32; i++) begin
        logic e;
        if (is_bw) e = d[(i/8)*8 + c];
        else       e = is_wr && (c == int'(c_a[2:0])) && !bm[i/8];
        if (wpb_on) e = e && mask_m[i];
        r[c*32+i] = e ? (is_bw ? color_m[i] : d[i]) : old[c*32+i];
      end
    return r;
  endfunction

  function automatic logic [7:0] model_bw_stb(input logic [31:0] d);
    logic [7:0] r;
    for (int c = 0; c < 8; c++) r[c] = d[c] | d[8+c] | d[16+c] | d[24+c];
    return r;
  endfunction

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic b, input logic [7:0] a,
                       input logic p, input logic [31:0] d, input logic [3:0] m);
    @(negedge clk);
    cmd = c; bank = b; col = a; ap = p; data = d; bmask = m;
    #1;
  endtask

  task automatic nop();
    drive(3'd0, 1'b0, 8'h00, 1'b0, 32'h0, 4'h0);
  endtask

  task automatic chk_write(input string req, input logic is_bw, input logic [7:0] a,
                           input logic [31:0] d, input logic [3:0] m, input logic b);
    logic [7:0] es;
    es = is_bw ? model_bw_stb(d) : (8'b1 << a[2:0]);
    check(req, {248'd0, stb}, {248'd0, es});
    check(req, wdata, model_data(is_bw, !is_bw, a, d, m, wpb_m[b]));
    check(req, {248'd0, base}, {248'd0, a & 8'hF8});
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10: quiet outputs after reset
    nop();
    check("R10", {253'd0, err, rej, apo}, 256'd0);
    check("R10", {248'd0, stb}, 256'd0);
    // R10: colour resets to zero, seen through a full block write
    drive(3'd4, 1'b0, 8'h13, 1'b0, 32'hFFFF_FFFF, 4'h0);
    chk_write("R10 R8", 1'b1, 8'h13, 32'hFFFF_FFFF, 4'h0, 1'b0);

    // R6 R7 R9: table of plain writes, masking off
    for (int k = 0; k < 6; k++) begin
      logic [52:0] v;
      v = VEC[k];
      drive(3'd3, 1'b0, v[48:41], v[40], v[39:8], v[52:49]);
      check("R7", {248'd0, stb}, {248'd0, v[7:0]});
      check("R6", wdata, model_data(1'b0, 1'b1, v[48:41], v[39:8], v[52:49], 1'b0));
      check("R7", {248'd0, base}, {248'd0, v[48:41] & 8'hF8});
      check("R9", {255'd0, apo}, {255'd0, v[40]});
    end

    // R1: load colour, then R3 lockout
    drive(3'd5, 1'b0, 8'h40, 1'b0, 32'hC0C0_1234, 4'h0);
    check("R1", {255'd0, err}, 256'd0);
    color_m = 32'hC0C0_1234;
    drive(3'd5, 1'b0, 8'h20, 1'b0, 32'h0000_0000, 4'h0); // would load mask
    check("R3", {255'd0, rej}, 256'd1);
    drive(3'd3, 1'b0, 8'h02, 1'b1, 32'h1111_2222, 4'h0);
    check("R3", {255'd0, rej}, 256'd1);
    check("R3", {247'd0, apo, stb}, 256'd0);
    nop();
    check("R3", {255'd0, rej}, 256'd0);
    // R8 R1: block write shows the new colour
    drive(3'd4, 1'b0, 8'h2A, 1'b1, 32'h81C3_0F5A, 4'h0);
    chk_write("R8 R1", 1'b1, 8'h2A, 32'h81C3_0F5A, 4'h0, 1'b0);
    check("R9", {255'd0, apo}, 256'd1);

    // R1: load mask; earlier refused load left it all ones
    drive(3'd5, 1'b0, 8'h20, 1'b0, 32'hF0F0_33CC, 4'h0);
    mask_m = 32'hF0F0_33CC;
    nop(); nop();
    // R4 R5: masking on bank 1 only
    drive(3'd2, 1'b1, 8'h00, 1'b0, 32'h0, 4'h0);
    wpb_m[1] = 1'b1;
    drive(3'd3, 1'b1, 8'h05, 1'b0, 32'h0F1E_2D3C, 4'b0010);
    chk_write("R5 R4", 1'b0, 8'h05, 32'h0F1E_2D3C, 4'b0010, 1'b1);
    check("R4", {255'd0, wbank}, 256'd1);
    drive(3'd3, 1'b0, 8'h05, 1'b0, 32'h0F1E_2D3C, 4'b0000);
    chk_write("R4", 1'b0, 8'h05, 32'h0F1E_2D3C, 4'b0000, 1'b0);
    drive(3'd4, 1'b1, 8'h60, 1'b0, 32'hFF00_FF0F, 4'h0);
    chk_write("R5 R8", 1'b1, 8'h60, 32'hFF00_FF0F, 4'h0, 1'b1);
    drive(3'd1, 1'b1, 8'h00, 1'b0, 32'h0, 4'h0);
    wpb_m[1] = 1'b0;
    drive(3'd3, 1'b1, 8'h0E, 1'b0, 32'hAAAA_5555, 4'b0000);
    chk_write("R4", 1'b0, 8'h0E, 32'hAAAA_5555, 4'b0000, 1'b1);

    // R2: dual-select load flags and changes nothing
    drive(3'd5, 1'b0, 8'h60, 1'b0, 32'h1357_9BDF, 4'h0);
    check("R2", {255'd0, err}, 256'd1);
    nop(); nop();
    drive(3'd4, 1'b0, 8'h00, 1'b0, 32'hFFFF_FFFF, 4'h0);
    chk_write("R2", 1'b1, 8'h00, 32'hFFFF_FFFF, 4'h0, 1'b0);
    drive(3'd2, 1'b0, 8'h00, 1'b0, 32'h0, 4'h0);
    wpb_m[0] = 1'b1;
    drive(3'd3, 1'b0, 8'h03, 1'b0, 32'h0000_0000, 4'h0);
    chk_write("R2 R5", 1'b0, 8'h03, 32'h0000_0000, 4'h0, 1'b0);

    // R9: auto-precharge ignored on other commands
    drive(3'd6, 1'b0, 8'h00, 1'b1, 32'h0, 4'h0);
    check("R9", {247'd0, apo, stb}, 256'd0);
    drive(3'd1, 1'b1, 8'h00, 1'b1, 32'h0, 4'h0);
    check("R9", {255'd0, apo}, 256'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule